// File: doc/BRIEF.md
# Banked Host Register Decoder for a Multi-Channel Analog Output Card

This block is the 16-bit host register window of an analog output card. The host presents an address offset with a write or read strobe. The block turns each access into register updates, single-cycle action pulses or read data. One bit in the first configuration register switches the low offsets between two banks. In the primary bank those offsets hold the digital output latch and two configuration words. In the alternate bank, writes to the same offsets become clear actions for interrupts and the DMA terminal count, and also drive the timing-bus shift and strobe.

DAC data registers sit at consecutive even offsets starting at 0x0C. Channel 0 shares 0x0C with the FIFO write port, so it can be written only while the alternate bank is selected. DAC codes arrive in offset-binary form and are stored and driven in two's complement. A read of the status offset returns the FIFO flags, the interrupt flags and the serial EEPROM bit. A read of 0x0C requests a FIFO clear.

Top module: `aout_regbank`

## Requirements
- R1: During and after a synchronous reset (rst_n low at a clock edge), cfg1_q, cfg2_q, cfg3_q, dout, fifo_wdata, tbus_data and every DAC channel are zero, the primary bank is selected and every pulse output is low.
- R2: A write to offset 0x0A loads cfg1_q from wdata on the next edge in either bank. cfg1_q bit 7 set selects the alternate bank.
- R3: In the primary bank, a write to 0x00 loads dout from wdata[7:0], a write to 0x02 loads cfg2_q and a write to 0x04 loads cfg3_q. No other access changes these registers.
- R4: In the alternate bank, writes to 0x00, 0x02 and 0x04 raise tc_clr, int1_clr and int2_clr respectively for exactly the cycle after the write edge, and leave dout, cfg2_q and cfg3_q unchanged.
- R5: In the alternate bank, a write to 0x06 pulses tbus_shift for one cycle and latches wdata[0] into tbus_data, and a write to 0x07 pulses tbus_strobe. In the primary bank both offsets are ignored.
- R6: DAC channel n (1 ≤ n < NCH) is written at offset 0x0C + 2n in either bank. Channel 0 (0x0C) is written only in the alternate bank. dac_code holds channel n at bits [12n+11:12n].
- R7: In the primary bank, a write to 0x0C pulses fifo_push for one cycle and loads fifo_wdata from wdata, without changing DAC channel 0.
- R8: A DAC channel stores wdata[11:0] with bit 11 inverted (offset binary to two's complement). wdata[15:12] are discarded.
- R9: dout_en[3:0] all equal cfg3_q bit 2, and dout_en[7:4] all equal cfg3_q bit 3.
- R10: With rd_en high at offset 0x0A, rdata in the same cycle is {9'b0, fifo_half, fifo_empty, fifo_full, int2, int1, tc, prom}, with fifo_half at bit 6 and prom at bit 0.
- R11: With rd_en high, offset 0x00 returns {8'b0, din}. Offset 0x0C returns zero and raises fifo_clr for the cycle after the edge.
- R12: Writes to undefined offsets (0x08, 0x09, odd offsets, 0x06/0x07 in the primary bank, DAC offsets at or beyond channel NCH) change no output. Reads of any offset other than 0x00, 0x0A and 0x0C, and any cycle with rd_en low, return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the current cycle |
| rd_en | input | 1 | Read strobe for the current cycle |
| addr | input | AW (5) | Byte offset of the access |
| wdata | input | DW (16) | Write data |
| rdata | output | DW (16) | Read data, combinational |
| din | input | 8 | Digital input pins |
| stat_fifo_half | input | 1 | FIFO half-full flag |
| stat_fifo_empty | input | 1 | FIFO empty flag |
| stat_fifo_full | input | 1 | FIFO full flag |
| stat_int2 | input | 1 | Interrupt 2 flag |
| stat_int1 | input | 1 | Interrupt 1 flag |
| stat_tc | input | 1 | Terminal-count interrupt flag |
| stat_prom | input | 1 | EEPROM serial output bit |
| dout | output | 8 | Digital output latch |
| dout_en | output | 8 | Per-bit output driver enables |
| cfg1_q | output | DW (16) | Configuration word 1 (bank select at bit 7) |
| cfg2_q | output | DW (16) | Configuration word 2 |
| cfg3_q | output | DW (16) | Configuration word 3 |
| fifo_push | output | 1 | One-cycle FIFO write pulse |
| fifo_wdata | output | DW (16) | Data of the last FIFO write |
| fifo_clr | output | 1 | One-cycle FIFO clear pulse |
| tc_clr | output | 1 | One-cycle DMA terminal-count clear |
| int1_clr | output | 1 | One-cycle interrupt 1 clear |
| int2_clr | output | 1 | One-cycle interrupt 2 clear |
| tbus_shift | output | 1 | One-cycle timing-bus shift pulse |
| tbus_data | output | 1 | Latched timing-bus shift bit |
| tbus_strobe | output | 1 | One-cycle timing-bus strobe |
| dac_code | output | NCH*CW (120) | Two's-complement codes of all DAC channels |

## Verification
Every register and pulse output changes at the first clock edge after the write or read strobe. The bank that applies is the one held in cfg1_q before that edge, so a write that flips the bank bit takes effect only for later accesses. rdata is combinational and is due in the same cycle as rd_en. The reference model therefore advances its state at each rising edge from the inputs held since the last one, and is compared with the outputs at the following falling edge. Read data is compared there against the inputs still being driven. Directed checks sample one nanosecond after the edge that registers the access, inside the cycle in which a pulse is high.

// File: rtl/aout_regbank_pkg.sv
// Package: shared offsets, bit positions and the write-decode type for the
// banked register decoder. Assumes byte offsets of at least 5 bits.
package aout_regbank_pkg;

    localparam logic [4:0] OFS_DIO       = 5'h00;
    localparam logic [4:0] OFS_CFG2      = 5'h02;
    localparam logic [4:0] OFS_CFG3      = 5'h04;
    localparam logic [4:0] OFS_TB_SHIFT  = 5'h06;
    localparam logic [4:0] OFS_TB_STROBE = 5'h07;
    localparam logic [4:0] OFS_CFG1      = 5'h0A;
    localparam logic [4:0] OFS_FIFO      = 5'h0C;

    localparam int BANK_BIT   = 7;
    localparam int DOE_LO_BIT = 2;
    localparam int DOE_HI_BIT = 3;
    localparam int DIO_W      = 8;
    localparam int STAT_W     = 7;

    typedef struct packed {
        logic cfg1_wr;
        logic dio_wr;
        logic cfg2_wr;
        logic cfg3_wr;
        logic fifo_wr;
        logic tc_clr;
        logic int1_clr;
        logic int2_clr;
        logic tb_shift;
        logic tb_strobe;
    } wr_dec_t;

endpackage

// File: rtl/aout_addr_dec.sv
// Module: write address decoder. Turns a write strobe, offset and the current
// bank bit into one strobe per target. Assumes one access per cycle.
module aout_addr_dec
    import aout_regbank_pkg::*;
#(
    parameter int AW  = 5,
    parameter int NCH = 10
) (
    input  logic           wr_en,
    input  logic [AW-1:0]  addr,
    input  logic           alt_bank,
    output wr_dec_t        dec,
    output logic [NCH-1:0] dac_sel
);

    // Decode the bank-dependent low offsets and the bank-independent cfg1.
    always_comb begin
        dec = '0;
        if (wr_en) begin
            if (addr == AW'(OFS_CFG1)) dec.cfg1_wr = 1'b1;
            if (!alt_bank) begin
                if (addr == AW'(OFS_DIO))  dec.dio_wr  = 1'b1;
                if (addr == AW'(OFS_CFG2)) dec.cfg2_wr = 1'b1;
                if (addr == AW'(OFS_CFG3)) dec.cfg3_wr = 1'b1;
                if (addr == AW'(OFS_FIFO)) dec.fifo_wr = 1'b1;
            end else begin
                if (addr == AW'(OFS_DIO))       dec.tc_clr    = 1'b1;
                if (addr == AW'(OFS_CFG2))      dec.int1_clr  = 1'b1;
                if (addr == AW'(OFS_CFG3))      dec.int2_clr  = 1'b1;
                if (addr == AW'(OFS_TB_SHIFT))  dec.tb_shift  = 1'b1;
                if (addr == AW'(OFS_TB_STROBE)) dec.tb_strobe = 1'b1;
            end
        end
    end

    // Channel 0 needs the alternate bank; the rest decode in both banks.
    assign dac_sel[0] = wr_en && alt_bank && (addr == AW'(OFS_FIFO));

    for (genvar n = 1; n < NCH; n++) begin : g_dac_hit
        assign dac_sel[n] = wr_en && (addr == AW'(int'(OFS_FIFO) + 2 * n));
    end

endmodule

// File: rtl/aout_ctrl_regs.sv
// Module: configuration words, digital output latch, FIFO write port and the
// one-cycle action pulses. Assumes the decoder gives at most one strobe.
module aout_ctrl_regs
    import aout_regbank_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wr_dec_t          dec,
    input  logic [DW-1:0]    wdata,
    input  logic             fifo_rd,
    output logic [DW-1:0]    cfg1_q,
    output logic [DW-1:0]    cfg2_q,
    output logic [DW-1:0]    cfg3_q,
    output logic [DIO_W-1:0] dout,
    output logic [DIO_W-1:0] dout_en,
    output logic             alt_bank,
    output logic             fifo_push,
    output logic [DW-1:0]    fifo_wdata,
    output logic             fifo_clr,
    output logic             tc_clr,
    output logic             int1_clr,
    output logic             int2_clr,
    output logic             tbus_shift,
    output logic             tbus_data,
    output logic             tbus_strobe
);

    localparam int HALF = DIO_W / 2;

    // Holding registers written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg1_q     <= '0;
            cfg2_q     <= '0;
            cfg3_q     <= '0;
            dout       <= '0;
            fifo_wdata <= '0;
            tbus_data  <= 1'b0;
        end else begin
            if (dec.cfg1_wr)  cfg1_q     <= wdata;
            if (dec.cfg2_wr)  cfg2_q     <= wdata;
            if (dec.cfg3_wr)  cfg3_q     <= wdata;
            if (dec.dio_wr)   dout       <= wdata[DIO_W-1:0];
            if (dec.fifo_wr)  fifo_wdata <= wdata;
            if (dec.tb_shift) tbus_data  <= wdata[0];
        end
    end

    // One-cycle action pulses, each registered from its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fifo_push   <= 1'b0;
            fifo_clr    <= 1'b0;
            tc_clr      <= 1'b0;
            int1_clr    <= 1'b0;
            int2_clr    <= 1'b0;
            tbus_shift  <= 1'b0;
            tbus_strobe <= 1'b0;
        end else begin
            fifo_push   <= dec.fifo_wr;
            fifo_clr    <= fifo_rd;
            tc_clr      <= dec.tc_clr;
            int1_clr    <= dec.int1_clr;
            int2_clr    <= dec.int2_clr;
            tbus_shift  <= dec.tb_shift;
            tbus_strobe <= dec.tb_strobe;
        end
    end

    assign alt_bank = cfg1_q[BANK_BIT];
    assign dout_en  = {{HALF{cfg3_q[DOE_HI_BIT]}}, {HALF{cfg3_q[DOE_LO_BIT]}}};

endmodule

// File: rtl/aout_dac_bank.sv
// Module: one data register per DAC channel. Each stores the offset-binary
// input with the top bit inverted. Assumes one-hot channel selects.
module aout_dac_bank #(
    parameter int NCH = 10,
    parameter int CW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NCH-1:0]    sel,
    input  logic [CW-1:0]     code_ob,
    output logic [NCH*CW-1:0] dac_code
);

    logic [CW-1:0] code_tc;

    // Offset binary to two's complement: flip the most significant bit.
    assign code_tc = {~code_ob[CW-1], code_ob[CW-2:0]};

    for (genvar n = 0; n < NCH; n++) begin : g_ch
        logic [CW-1:0] code_q;
        // Channel register, loaded when its select is high.
        always_ff @(posedge clk) begin
            if (!rst_n)      code_q <= '0;
            else if (sel[n]) code_q <= code_tc;
        end
        assign dac_code[n*CW +: CW] = code_q;
    end

endmodule

// File: rtl/aout_read_mux.sv
// Module: combinational read path. It returns the digital inputs or the status
// word and gives zero elsewhere. Reads of the FIFO offset return zero.
module aout_read_mux
    import aout_regbank_pkg::*;
#(
    parameter int AW = 5,
    parameter int DW = 16
) (
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DIO_W-1:0]  din,
    input  logic [STAT_W-1:0] status,
    output logic [DW-1:0]     rdata
);

    // Select the read source by offset.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (addr == AW'(OFS_DIO))  rdata = {{(DW-DIO_W){1'b0}}, din};
            if (addr == AW'(OFS_CFG1)) rdata = {{(DW-STAT_W){1'b0}}, status};
        end
    end

endmodule

// File: rtl/aout_regbank.sv
// Module: banked host register decoder top. It ties the decoder, the control
// registers, the DAC bank and the read path together. Assumes a synchronous host
// that raises at most one of wr_en or rd_en per cycle.
module aout_regbank
    import aout_regbank_pkg::*;
#(
    parameter int NCH = 10,
    parameter int CW  = 12,
    parameter int DW  = 16,
    parameter int AW  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [AW-1:0]     addr,
    input  logic [DW-1:0]     wdata,
    output logic [DW-1:0]     rdata,
    input  logic [7:0]        din,
    input  logic              stat_fifo_half,
    input  logic              stat_fifo_empty,
    input  logic              stat_fifo_full,
    input  logic              stat_int2,
    input  logic              stat_int1,
    input  logic              stat_tc,
    input  logic              stat_prom,
    output logic [7:0]        dout,
    output logic [7:0]        dout_en,
    output logic [DW-1:0]     cfg1_q,
    output logic [DW-1:0]     cfg2_q,
    output logic [DW-1:0]     cfg3_q,
    output logic              fifo_push,
    output logic [DW-1:0]     fifo_wdata,
    output logic              fifo_clr,
    output logic              tc_clr,
    output logic              int1_clr,
    output logic              int2_clr,
    output logic              tbus_shift,
    output logic              tbus_data,
    output logic              tbus_strobe,
    output logic [NCH*CW-1:0] dac_code
);

    wr_dec_t           dec;
    logic [NCH-1:0]    dac_sel;
    logic              alt_bank;
    logic              fifo_rd;
    logic [STAT_W-1:0] status;

    assign fifo_rd = rd_en && (addr == AW'(OFS_FIFO));
    assign status  = {stat_fifo_half, stat_fifo_empty, stat_fifo_full,
                      stat_int2, stat_int1, stat_tc, stat_prom};

    aout_addr_dec #(.AW(AW), .NCH(NCH)) u_dec (
        .wr_en    (wr_en),
        .addr     (addr),
        .alt_bank (alt_bank),
        .dec      (dec),
        .dac_sel  (dac_sel)
    );

    aout_ctrl_regs #(.DW(DW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .dec         (dec),
        .wdata       (wdata),
        .fifo_rd     (fifo_rd),
        .cfg1_q      (cfg1_q),
        .cfg2_q      (cfg2_q),
        .cfg3_q      (cfg3_q),
        .dout        (dout),
        .dout_en     (dout_en),
        .alt_bank    (alt_bank),
        .fifo_push   (fifo_push),
        .fifo_wdata  (fifo_wdata),
        .fifo_clr    (fifo_clr),
        .tc_clr      (tc_clr),
        .int1_clr    (int1_clr),
        .int2_clr    (int2_clr),
        .tbus_shift  (tbus_shift),
        .tbus_data   (tbus_data),
        .tbus_strobe (tbus_strobe)
    );

    aout_dac_bank #(.NCH(NCH), .CW(CW)) u_dac (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (dac_sel),
        .code_ob  (wdata[CW-1:0]),
        .dac_code (dac_code)
    );

    aout_read_mux #(.AW(AW), .DW(DW)) u_rd (
        .rd_en  (rd_en),
        .addr   (addr),
        .din    (din),
        .status (status),
        .rdata  (rdata)
    );

endmodule

// File: rtl/aout_regbank_chk.sv
// Module: protocol checker for the banked register decoder, bound to the top.
module aout_regbank_chk #(
    parameter int NCH = 10,
    parameter int CW  = 12,
    parameter int DW  = 16,
    parameter int AW  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [AW-1:0]     addr,
    input logic [DW-1:0]     rdata,
    input logic [7:0]        dout,
    input logic [7:0]        dout_en,
    input logic [DW-1:0]     cfg1_q,
    input logic [DW-1:0]     cfg3_q,
    input logic              fifo_push,
    input logic              fifo_clr,
    input logic              tc_clr,
    input logic              int1_clr,
    input logic              int2_clr,
    input logic              tbus_shift,
    input logic              tbus_strobe,
    input logic [NCH*CW-1:0] dac_code
);

    // A terminal-count clear follows an alternate-bank write to offset 0.
    assert_clear_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tc_clr |-> $past(wr_en && addr == AW'(0) && cfg1_q[7]));

    // Clear and timing-bus pulses never overlap.
    assert_pulse_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({tc_clr, int1_clr, int2_clr, tbus_shift, tbus_strobe, fifo_push}));

    // A FIFO push follows a primary-bank write to 0x0C.
    assert_fifo_push_bank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> $past(wr_en && addr == AW'(12) && !cfg1_q[7]));

    // DAC channel 0 holds unless written in the alternate bank.
    assert_dac0_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en && addr == AW'(12) && cfg1_q[7]))
        |-> $stable(dac_code[CW-1:0]));

    // The digital output latch holds unless written in the primary bank.
    assert_dout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en && addr == AW'(0) && !cfg1_q[7]))
        |-> $stable(dout));

    // A FIFO clear follows a read of 0x0C.
    assert_fifo_clr_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_clr |-> $past(rd_en && addr == AW'(12)));

    // Reads of undefined offsets return zero.
    assert_undef_read_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr != AW'(0) && addr != AW'(10) && addr != AW'(12))
        |-> (rdata == '0));

    // Nibble enables follow the two configuration-3 bits.
    assert_dout_en_R9: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en == {{4{cfg3_q[3]}}, {4{cfg3_q[2]}}});

endmodule

bind aout_regbank aout_regbank_chk #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .rdata       (rdata),
    .dout        (dout),
    .dout_en     (dout_en),
    .cfg1_q      (cfg1_q),
    .cfg3_q      (cfg3_q),
    .fifo_push   (fifo_push),
    .fifo_clr    (fifo_clr),
    .tc_clr      (tc_clr),
    .int1_clr    (int1_clr),
    .int2_clr    (int2_clr),
    .tbus_shift  (tbus_shift),
    .tbus_strobe (tbus_strobe),
    .dac_code    (dac_code)
);

// File: tb/aout_regbank_bench.sv
// Bench: directed and random accesses, checked every cycle against a
// behavioural reference model.
module aout_regbank_bench;

    localparam int NCH = 10;
    localparam int CW  = 12;
    localparam int DW  = 16;
    localparam int AW  = 5;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [AW-1:0]     addr  = '0;
    logic [DW-1:0]     wdata = '0;
    logic [DW-1:0]     rdata;
    logic [7:0]        din   = '0;
    logic [6:0]        stat  = '0;
    logic [7:0]        dout, dout_en;
    logic [DW-1:0]     cfg1_q, cfg2_q, cfg3_q, fifo_wdata;
    logic              fifo_push, fifo_clr, tc_clr, int1_clr, int2_clr;
    logic              tbus_shift, tbus_data, tbus_strobe;
    logic [NCH*CW-1:0] dac_code;

    aout_regbank #(.NCH(NCH), .CW(CW), .DW(DW), .AW(AW)) u_aout_regbank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .din(din),
        .stat_fifo_half(stat[6]), .stat_fifo_empty(stat[5]), .stat_fifo_full(stat[4]),
        .stat_int2(stat[3]), .stat_int1(stat[2]), .stat_tc(stat[1]), .stat_prom(stat[0]),
        .dout(dout), .dout_en(dout_en), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q),
        .cfg3_q(cfg3_q), .fifo_push(fifo_push), .fifo_wdata(fifo_wdata),
        .fifo_clr(fifo_clr), .tc_clr(tc_clr), .int1_clr(int1_clr),
        .int2_clr(int2_clr), .tbus_shift(tbus_shift), .tbus_data(tbus_data),
        .tbus_strobe(tbus_strobe), .dac_code(dac_code)
    );

    int checks = 0;
    int errors = 0;
    bit cmp_en = 1'b0;
    bit done   = 1'b0;

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state
    logic [15:0] m_cfg1 = '0, m_cfg2 = '0, m_cfg3 = '0, m_fwd = '0;
    logic [7:0]  m_dout = '0;
    logic [11:0] m_dac [NCH];
    bit m_push, m_fclr, m_tc, m_i1, m_i2, m_shift, m_tdata, m_strobe;

    initial for (int n = 0; n < NCH; n++) m_dac[n] = '0;

    // Model update at each rising edge from the held inputs
    always @(posedge clk) begin : model
        int a;
        a = int'(addr);
        m_push <= 0; m_fclr <= 0; m_tc <= 0; m_i1 <= 0; m_i2 <= 0;
        m_shift <= 0; m_strobe <= 0;
        if (!rst_n) begin
            m_cfg1 <= 0; m_cfg2 <= 0; m_cfg3 <= 0; m_fwd <= 0; m_dout <= 0;
            m_tdata <= 0;
            for (int n = 0; n < NCH; n++) m_dac[n] <= 0;
        end else begin
            if (wr_en) begin
                if (a == 10) m_cfg1 <= wdata;
                if (!m_cfg1[7]) begin
                    case (a)
                        0:  m_dout <= wdata[7:0];
                        2:  m_cfg2 <= wdata;
                        4:  m_cfg3 <= wdata;
                        12: begin m_push <= 1; m_fwd <= wdata; end
                        default: ;
                    endcase
                end else begin
                    case (a)
                        0:  m_tc <= 1;
                        2:  m_i1 <= 1;
                        4:  m_i2 <= 1;
                        6:  begin m_shift <= 1; m_tdata <= wdata[0]; end
                        7:  m_strobe <= 1;
                        12: m_dac[0] <= {~wdata[11], wdata[10:0]};
                        default: ;
                    endcase
                end
                if (a >= 14 && a % 2 == 0 && (a - 12) / 2 < NCH)
                    m_dac[(a - 12) / 2] <= {~wdata[11], wdata[10:0]};
            end
            if (rd_en && a == 12) m_fclr <= 1;
        end
    end

    // Compare every output at the falling edge
    always @(negedge clk) begin
        if (cmp_en) begin
            logic [15:0] exp_rd;
            string rtag;
            exp_rd = 0;
            rtag = "R12";
            if (rd_en && addr == 0)  begin exp_rd = {8'h0, din};  rtag = "R11"; end
            if (rd_en && addr == 10) begin exp_rd = {9'h0, stat}; rtag = "R10"; end
            if (rd_en && addr == 12) rtag = "R11";
            chk(rtag, "rdata", rdata, exp_rd);
            chk("R2", "cfg1_q", cfg1_q, m_cfg1);
            chk("R3", "cfg2_q", cfg2_q, m_cfg2);
            chk("R3", "cfg3_q", cfg3_q, m_cfg3);
            chk("R3", "dout", dout, m_dout);
            chk("R9", "dout_en", dout_en, {{4{m_cfg3[3]}}, {4{m_cfg3[2]}}});
            chk("R4", "clears", {tc_clr, int1_clr, int2_clr}, {m_tc, m_i1, m_i2});
            chk("R5", "tbus", {tbus_shift, tbus_data, tbus_strobe}, {m_shift, m_tdata, m_strobe});
            chk("R7", "fifo_push", {fifo_push, fifo_wdata}, {m_push, m_fwd});
            chk("R11", "fifo_clr", fifo_clr, m_fclr);
            for (int n = 0; n < NCH; n++)
                chk("R6", $sformatf("dac%0d", n), dac_code[n*CW +: CW], m_dac[n]);
        end
    end

    task automatic wr(input int a, input logic [15:0] d);
        @(posedge clk); #1;
        wr_en = 1; rd_en = 0; addr = AW'(a); wdata = d;
        @(posedge clk); #1;
        wr_en = 0;
    endtask

    task automatic rd(input int a, output logic [15:0] v);
        @(posedge clk); #1;
        rd_en = 1; wr_en = 0; addr = AW'(a);
        #1 v = rdata;
        @(posedge clk); #1;
        rd_en = 0;
    endtask

    initial begin : watchdog
        #(4 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : stim
        logic [15:0] v;
        @(posedge clk); #1;
        cmp_en = 1;
        repeat (2) @(posedge clk);
        #1;
        // R1: reset state
        chk("R1", "reset cfg", {cfg1_q[7:0], cfg2_q[7:0], cfg3_q[7:0]}, 0);
        chk("R1", "reset dac", dac_code[31:0], 0);
        chk("R1", "reset pulses", {fifo_push, fifo_clr, tc_clr, tbus_shift, tbus_strobe}, 0);
        rst_n = 1;

        // R3 / R9: primary bank registers
        wr(4, 16'h0004);
        chk("R9", "low nibble enable", dout_en, 8'h0F);
        wr(4, 16'h0008);
        chk("R9", "high nibble enable", dout_en, 8'hF0);
        wr(0, 16'h12A5);
        chk("R3", "dout write", dout, 8'hA5);
        wr(2, 16'hBEEF);
        chk("R3", "cfg2 write", cfg2_q, 16'hBEEF);

        // R7: FIFO write in primary bank, DAC0 untouched
        wr(12, 16'h0ABC);
        chk("R7", "fifo push", {fifo_push, fifo_wdata}, {1'b1, 16'h0ABC});
        chk("R7", "dac0 untouched", dac_code[11:0], 0);

        // R8 / R6: upper DAC channels, conversion
        wr(14, 16'hF123);
        chk("R8", "dac1 conversion", dac_code[23:12], 12'h923);
        wr(30, 16'h0800);
        chk("R6", "dac9 write", dac_code[119:108], 12'h000);

        // R5 / R12: timing offsets ignored in primary bank
        wr(6, 16'h0001);
        chk("R5", "shift ignored in primary", {tbus_shift, tbus_data}, 0);
        wr(7, 16'h0001);
        chk("R12", "strobe ignored in primary", tbus_strobe, 0);

        // R10 / R11: reads
        stat = 7'b1010011; din = 8'h5C;
        rd(10, v);
        chk("R10", "status read", v, 16'h0053);
        rd(0, v);
        chk("R11", "din read", v, 16'h005C);
        rd(12, v);
        chk("R11", "fifo clear pulse", fifo_clr, 1);

        // R2: enter alternate bank
        wr(10, 16'h0F83);
        chk("R2", "bank select", cfg1_q, 16'h0F83);

        // R4: clears, registers unchanged
        wr(0, 16'h00FF);
        chk("R4", "tc clear", {tc_clr, dout}, {1'b1, 8'hA5});
        wr(2, 16'h0000);
        chk("R4", "int1 clear", {int1_clr, cfg2_q}, {1'b1, 16'hBEEF});
        wr(4, 16'h0000);
        chk("R4", "int2 clear", {int2_clr, cfg3_q[3:0]}, {1'b1, 4'h8});

        // R5: timing bus in alternate bank
        wr(6, 16'hFFFF);
        chk("R5", "shift pulse", {tbus_shift, tbus_data}, 2'b11);
        wr(7, 16'h0000);
        chk("R5", "strobe pulse", tbus_strobe, 1);

        // R6: DAC0 in alternate bank
        wr(12, 16'h0FFF);
        chk("R6", "dac0 alternate", {fifo_push, dac_code[11:0]}, {1'b0, 12'h7FF});

        // R12: undefined writes and reads
        wr(8, 16'hFFFF);
        wr(9, 16'hFFFF);
        wr(31, 16'hFFFF);
        chk("R12", "undefined writes", {dac_code[119:108], cfg1_q}, {12'h000, 16'h0F83});
        rd(2, v);
        chk("R12", "undefined read", v, 0);

        wr(10, 16'h0000);

        // Random traffic compared every cycle
        for (int i = 0; i < 3000; i++) begin
            @(posedge clk); #1;
            addr  = AW'($urandom % 32);
            wdata = 16'($urandom);
            din   = 8'($urandom);
            stat  = 7'($urandom);
            wr_en = ($urandom % 3) == 0;
            rd_en = !wr_en && (($urandom % 2) == 0);
            rst_n = ($urandom % 500) != 0;
        end
        @(posedge clk); #1;
        wr_en = 0; rd_en = 0; rst_n = 1;
        repeat (3) @(posedge clk);
        #1;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule